// File: doc/BRIEF.md
# Float Round-to-Integral Unit

This block takes one single-precision floating-point word and returns the nearest integral value in the chosen direction, still encoded as single precision. The work is done on the raw encoding: an exponent-dependent mask marks the fraction bits that hold the value's sub-unit part. Those bits are cleared, and when rounding away from zero a bias is added first. A carry out of the fraction moves into the exponent field with no extra logic.

A 2-bit selector chooses one of four directions: nearest with ties away from zero, toward zero, toward plus infinity and toward minus infinity. The two directed modes are not separate circuits. Each picks either the truncated result or the magnitude-rounded-up result from the sign of the operand. The datapath is combinational and feeds one output register, so a result appears one cycle after its operand is presented.

Top module: `fp_round_int`

## Requirements
- R1: A NaN operand (exponent field 255, fraction non-zero) returns the same word with fraction bit 22 set, in every mode.
- R2: An operand with exponent field of 150 or more, meaning it is already integral or is an infinity, is returned unchanged in every mode.
- R3: Mode 1 (toward zero) clears every fraction bit below the binary point. An operand of magnitude below 1.0 becomes a zero with the operand's sign. The magnitude never grows.
- R4: Rounding the magnitude up (positive operands in mode 2, negative operands in mode 3) returns a zero of either sign unchanged. It turns any non-zero operand below magnitude 1.0, denormals included, into 1.0 with the operand's sign (0x3F800000 plus the sign bit). Otherwise it goes to the next integer of larger magnitude.
- R5: Mode 0 (nearest) maps magnitudes below 0.5 to a signed zero. It maps magnitudes from 0.5 up to but not including 1.0 to a signed 1.0.
- R6: Mode 0 with magnitude of 1.0 or more rounds to the nearest integer, and an exact half goes away from zero (2.5 becomes 3.0, -1.5 becomes -2.0).
- R7: Mode 2 (toward plus infinity) truncates negative operands and rounds positive ones up in magnitude. Mode 3 (toward minus infinity) does the opposite. The result always keeps the operand's sign.
- R8: The mode codes are 0 nearest, 1 toward zero, 2 toward plus infinity, 3 toward minus infinity.
- R9: out_valid is high in exactly the cycle after a cycle with in_valid high, and out_result changes only after an accepted operand.
- R10: While rst_n is low at a clock edge, out_valid and out_result are cleared to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operand and mode are present this cycle |
| in_operand | input | 32 | Single-precision operand |
| in_mode | input | 2 | Rounding direction code |
| out_valid | output | 1 | out_result holds a new result |
| out_result | output | 32 | Rounded single-precision result |

## Verification
The hardest case to reach is the one where adding the rounding bias carries out of the whole fraction into the exponent. It shows only for operands whose fractional part lies right next to the boundary. The stimulus drives values such as 8388607.5 (the largest non-integral single), values just below 1.0 and the half-way points ±1.5 and ±2.5 through every mode. Each of these lands on a power-of-two boundary or on a tie. Denormals and ±0 are added to exercise the paths for magnitudes below one, where the mask shift is never used.

// File: rtl/fri_pkg.sv
// Shared constants and the mode type for the round-to-integral unit.
// Assumes the single-precision layout: 1 sign, 8 exponent, 23 fraction bits.
package fri_pkg;
    localparam int WORD_W = 32;
    localparam int EXP_W  = 8;
    localparam int FRAC_W = 23;
    localparam int BIAS   = 127;

    typedef enum logic [1:0] {
        RND_NEAREST = 2'd0,
        RND_ZERO    = 2'd1,
        RND_POS     = 2'd2,
        RND_NEG     = 2'd3
    } rnd_mode_e;
endpackage

// File: rtl/fri_decode.sv
// Classifies the operand and builds the fraction masks for its exponent.
// Assumes masks are only used when the unbiased exponent is 0..FRAC_W-1;
// outside that range the select stage overrides the masked results.
module fri_decode #(
    parameter int WORD_W = fri_pkg::WORD_W,
    parameter int EXP_W  = fri_pkg::EXP_W,
    parameter int FRAC_W = fri_pkg::FRAC_W,
    parameter int BIAS   = fri_pkg::BIAS
) (
    input  logic [WORD_W-1:0] op,
    output logic              is_nan,
    output logic              is_big,
    output logic              is_zero,
    output logic              below_one,
    output logic              at_half_exp,
    output logic [FRAC_W-1:0] frac_mask,
    output logic [FRAC_W-1:0] half_bias
);
    localparam int SH_W = $clog2(FRAC_W);
    localparam logic [FRAC_W-1:0] ALL_FRAC = {FRAC_W{1'b1}};
    localparam logic [FRAC_W-1:0] TOP_FRAC = FRAC_W'(1) << (FRAC_W - 1);

    logic [EXP_W-1:0]  exp_f;
    logic [FRAC_W-1:0] frac_f;
    logic [SH_W-1:0]   shamt;

    // Field split, class flags and shift amount for the masks.
    always_comb begin
        exp_f       = op[WORD_W-2 -: EXP_W];
        frac_f      = op[FRAC_W-1:0];
        is_nan      = (&exp_f) && (|frac_f);
        is_big      = exp_f >= EXP_W'(BIAS + FRAC_W);
        is_zero     = ~|op[WORD_W-2:0];
        below_one   = exp_f < EXP_W'(BIAS);
        at_half_exp = exp_f == EXP_W'(BIAS - 1);
        shamt       = SH_W'(exp_f - EXP_W'(BIAS));
        frac_mask   = ALL_FRAC >> shamt;
        half_bias   = TOP_FRAC >> shamt;
    end
endmodule

// File: rtl/fri_paths.sv
// Computes the three masked candidates: truncate, magnitude-up, nearest.
// Assumes a carry out of the fraction may enter the exponent; it can never
// reach the sign bit because integral-already operands are passed around.
module fri_paths #(
    parameter int WORD_W = fri_pkg::WORD_W,
    parameter int FRAC_W = fri_pkg::FRAC_W
) (
    input  logic [WORD_W-1:0] op,
    input  logic [FRAC_W-1:0] frac_mask,
    input  logic [FRAC_W-1:0] half_bias,
    output logic [WORD_W-1:0] trunc_val,
    output logic [WORD_W-1:0] up_val,
    output logic [WORD_W-1:0] near_val
);
    localparam int HI_W = WORD_W - FRAC_W;

    logic [WORD_W-1:0] keep;
    logic [WORD_W-1:0] up_sum;
    logic [WORD_W-1:0] near_sum;

    // Add the bias for each direction, then clear the sub-unit bits.
    always_comb begin
        keep      = {{HI_W{1'b1}}, ~frac_mask};
        up_sum    = op + {{HI_W{1'b0}}, frac_mask};
        near_sum  = op + {{HI_W{1'b0}}, half_bias};
        trunc_val = op & keep;
        up_val    = up_sum & keep;
        near_val  = near_sum & keep;
    end
endmodule

// File: rtl/fri_select.sv
// Applies the small-magnitude and special cases and picks the mode result.
// Directed modes choose truncate or magnitude-up from the operand sign.
module fri_select #(
    parameter int WORD_W = fri_pkg::WORD_W,
    parameter int FRAC_W = fri_pkg::FRAC_W,
    parameter int BIAS   = fri_pkg::BIAS
) (
    input  logic [WORD_W-1:0] op,
    input  fri_pkg::rnd_mode_e mode,
    input  logic              is_nan,
    input  logic              is_big,
    input  logic              is_zero,
    input  logic              below_one,
    input  logic              at_half_exp,
    input  logic [WORD_W-1:0] trunc_val,
    input  logic [WORD_W-1:0] up_val,
    input  logic [WORD_W-1:0] near_val,
    output logic [WORD_W-1:0] result
);
    localparam logic [WORD_W-1:0] ONE_ENC  = WORD_W'(BIAS) << FRAC_W;
    localparam logic [WORD_W-1:0] QUIET    = WORD_W'(1) << (FRAC_W - 1);

    logic [WORD_W-1:0] sign_only;
    logic [WORD_W-1:0] sign_one;
    logic [WORD_W-1:0] tz_res;
    logic [WORD_W-1:0] mu_res;
    logic [WORD_W-1:0] nr_res;
    logic              neg;

    // Candidate results after the below-one overrides.
    always_comb begin
        neg       = op[WORD_W-1];
        sign_only = {neg, {(WORD_W-1){1'b0}}};
        sign_one  = sign_only | ONE_ENC;
        tz_res    = below_one ? sign_only : trunc_val;
        if (is_zero)        mu_res = op;
        else if (below_one) mu_res = sign_one;
        else                mu_res = up_val;
        if (at_half_exp)    nr_res = sign_one;
        else if (below_one) nr_res = sign_only;
        else                nr_res = near_val;
    end

    // Mode choice with NaN and already-integral overrides on top.
    always_comb begin
        unique case (mode)
            fri_pkg::RND_NEAREST: result = nr_res;
            fri_pkg::RND_ZERO:    result = tz_res;
            fri_pkg::RND_POS:     result = neg ? tz_res : mu_res;
            default:              result = neg ? mu_res : tz_res;
        endcase
        if (is_nan)      result = op | QUIET;
        else if (is_big) result = op;
    end
endmodule

// File: rtl/fp_round_int.sv
// Top of the round-to-integral unit: combinational datapath, one output
// register. Assumes in_operand and in_mode are stable while in_valid is high.
module fp_round_int #(
    parameter int WORD_W = fri_pkg::WORD_W,
    parameter int EXP_W  = fri_pkg::EXP_W,
    parameter int FRAC_W = fri_pkg::FRAC_W,
    parameter int BIAS   = fri_pkg::BIAS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_operand,
    input  logic [1:0]        in_mode,
    output logic              out_valid,
    output logic [WORD_W-1:0] out_result
);
    logic              is_nan, is_big, is_zero, below_one, at_half_exp;
    logic [FRAC_W-1:0] frac_mask, half_bias;
    logic [WORD_W-1:0] trunc_val, up_val, near_val, next_res;
    fri_pkg::rnd_mode_e mode_sel;

    // Map the raw selector onto the mode type.
    always_comb mode_sel = fri_pkg::rnd_mode_e'(in_mode);

    fri_decode #(.WORD_W(WORD_W), .EXP_W(EXP_W), .FRAC_W(FRAC_W), .BIAS(BIAS)) i_decode (
        .op(in_operand), .is_nan(is_nan), .is_big(is_big), .is_zero(is_zero),
        .below_one(below_one), .at_half_exp(at_half_exp),
        .frac_mask(frac_mask), .half_bias(half_bias)
    );

    fri_paths #(.WORD_W(WORD_W), .FRAC_W(FRAC_W)) i_paths (
        .op(in_operand), .frac_mask(frac_mask), .half_bias(half_bias),
        .trunc_val(trunc_val), .up_val(up_val), .near_val(near_val)
    );

    fri_select #(.WORD_W(WORD_W), .FRAC_W(FRAC_W), .BIAS(BIAS)) i_select (
        .op(in_operand), .mode(mode_sel), .is_nan(is_nan), .is_big(is_big),
        .is_zero(is_zero), .below_one(below_one), .at_half_exp(at_half_exp),
        .trunc_val(trunc_val), .up_val(up_val), .near_val(near_val),
        .result(next_res)
    );

    // Output register: capture a result for each accepted operand.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            out_result <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) out_result <= next_res;
        end
    end
endmodule

// File: rtl/fri_checker.sv
// Temporal checks for the round-to-integral unit, bound to its top.
// Assumes the port names and the single-precision layout of the top.
module fri_checker #(
    parameter int WORD_W = fri_pkg::WORD_W,
    parameter int FRAC_W = fri_pkg::FRAC_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [WORD_W-1:0] in_operand,
    input logic [1:0]        in_mode,
    input logic              out_valid,
    input logic [WORD_W-1:0] out_result
);
    localparam logic [WORD_W-1:0] QUIET = WORD_W'(1) << (FRAC_W - 1);
    logic op_nan, op_big;

    // Operand classes used by the properties.
    always_comb begin
        op_nan = (&in_operand[WORD_W-2:FRAC_W]) && (|in_operand[FRAC_W-1:0]);
        op_big = in_operand[WORD_W-2:FRAC_W] >= 8'd150;
    end

    assert_valid_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    assert_valid_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    assert_hold_when_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_result));
    assert_nan_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_nan) |=> out_result == ($past(in_operand) | QUIET));
    assert_integral_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_big && !op_nan) |=> out_result == $past(in_operand));
    assert_sign_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_result[WORD_W-1] == $past(in_operand[WORD_W-1]));
    assert_trunc_no_grow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_mode == 2'd1 && !op_nan)
        |=> out_result[WORD_W-2:0] <= $past(in_operand[WORD_W-2:0]));
    assert_up_no_shrink_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_mode == 2'd2 && !in_operand[WORD_W-1] && !op_nan)
        |=> out_result[WORD_W-2:0] >= $past(in_operand[WORD_W-2:0]));
endmodule

bind fp_round_int fri_checker #(.WORD_W(WORD_W), .FRAC_W(FRAC_W)) i_fri_checker (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_operand(in_operand),
    .in_mode(in_mode), .out_valid(out_valid), .out_result(out_result)
);

// File: tb/test_fp_round_int.sv
// Directed bench for fp_round_int: one task per scenario, each self-checking.
module test_fp_round_int;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_operand = '0;
    logic [1:0]  in_mode = '0;
    logic        out_valid;
    logic [31:0] out_result;
    int          n_checks = 0;
    int          n_errors = 0;

    always #5 clk = ~clk;

    fp_round_int i_fp_round_int (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_operand(in_operand),
        .in_mode(in_mode), .out_valid(out_valid), .out_result(out_result)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp_v);
        n_checks++;
        if (act !== exp_v) begin
            n_errors++;
            $display("FAIL %s: actual=%08h expected=%08h", tag, act, exp_v);
        end
    endtask

    // Present one operand, then check valid and result one cycle later.
    task automatic run_case(input logic [31:0] op, input logic [1:0] md,
                            input logic [31:0] exp_v, input string tag);
        @(negedge clk);
        in_valid = 1'b1; in_operand = op; in_mode = md;
        @(negedge clk);
        in_valid = 1'b0;
        check("R9", {31'd0, out_valid}, 32'd1);
        check(tag, out_result, exp_v);
    endtask

    // All four modes for one operand; expected order nearest, zero, +inf, -inf.
    task automatic all_modes(input logic [31:0] op, input logic [31:0] e0, input logic [31:0] e1,
                             input logic [31:0] e2, input logic [31:0] e3, input string tag);
        run_case(op, 2'd0, e0, tag);
        run_case(op, 2'd1, e1, tag);
        run_case(op, 2'd2, e2, tag);
        run_case(op, 2'd3, e3, tag);
    endtask

    task automatic test_reset();   // R10
        @(negedge clk);
        check("R10", {31'd0, out_valid}, 32'd0);
        check("R10", out_result, 32'd0);
    endtask

    task automatic test_zeros();   // R4, R5, R3
        all_modes(32'h0000_0000, 32'h0000_0000, 32'h0000_0000, 32'h0000_0000, 32'h0000_0000, "R4");
        all_modes(32'h8000_0000, 32'h8000_0000, 32'h8000_0000, 32'h8000_0000, 32'h8000_0000, "R4");
    endtask

    task automatic test_halves();  // R5, R7, R8
        all_modes(32'h3F00_0000, 32'h3F80_0000, 32'h0000_0000, 32'h3F80_0000, 32'h0000_0000, "R5");
        all_modes(32'hBF00_0000, 32'hBF80_0000, 32'h8000_0000, 32'h8000_0000, 32'hBF80_0000, "R7");
        all_modes(32'h3E80_0000, 32'h0000_0000, 32'h0000_0000, 32'h3F80_0000, 32'h0000_0000, "R5");
        all_modes(32'h3F7F_FFFF, 32'h3F80_0000, 32'h0000_0000, 32'h3F80_0000, 32'h0000_0000, "R8");
    endtask

    task automatic test_ties();    // R6, R3, R7
        all_modes(32'h3FC0_0000, 32'h4000_0000, 32'h3F80_0000, 32'h4000_0000, 32'h3F80_0000, "R6");
        all_modes(32'hBFC0_0000, 32'hC000_0000, 32'hBF80_0000, 32'hBF80_0000, 32'hC000_0000, "R6");
        all_modes(32'h4020_0000, 32'h4040_0000, 32'h4000_0000, 32'h4040_0000, 32'h4000_0000, "R6");
        all_modes(32'hC020_0000, 32'hC040_0000, 32'hC000_0000, 32'hC000_0000, 32'hC040_0000, "R7");
    endtask

    task automatic test_near_integers();  // R3, R4, R6
        all_modes(32'h4AFF_FFFF, 32'h4B00_0000, 32'h4AFF_FFFE, 32'h4B00_0000, 32'h4AFF_FFFE, "R3");
        all_modes(32'h4040_0000, 32'h4040_0000, 32'h4040_0000, 32'h4040_0000, 32'h4040_0000, "R4");
        all_modes(32'h3FFF_FFFF, 32'h4000_0000, 32'h3F80_0000, 32'h4000_0000, 32'h3F80_0000, "R6");
    endtask

    task automatic test_specials();  // R1, R2
        all_modes(32'h4B00_0000, 32'h4B00_0000, 32'h4B00_0000, 32'h4B00_0000, 32'h4B00_0000, "R2");
        all_modes(32'hCB40_0001, 32'hCB40_0001, 32'hCB40_0001, 32'hCB40_0001, 32'hCB40_0001, "R2");
        all_modes(32'h7F80_0000, 32'h7F80_0000, 32'h7F80_0000, 32'h7F80_0000, 32'h7F80_0000, "R2");
        all_modes(32'hFF80_0000, 32'hFF80_0000, 32'hFF80_0000, 32'hFF80_0000, 32'hFF80_0000, "R2");
        all_modes(32'h7F80_0001, 32'h7FC0_0001, 32'h7FC0_0001, 32'h7FC0_0001, 32'h7FC0_0001, "R1");
        all_modes(32'hFFC0_0000, 32'hFFC0_0000, 32'hFFC0_0000, 32'hFFC0_0000, 32'hFFC0_0000, "R1");
    endtask

    task automatic test_denormals();  // R4, R5, R3
        all_modes(32'h0000_0001, 32'h0000_0000, 32'h0000_0000, 32'h3F80_0000, 32'h0000_0000, "R4");
        all_modes(32'h8040_0000, 32'h8000_0000, 32'h8000_0000, 32'h8000_0000, 32'hBF80_0000, "R4");
    endtask

    task automatic test_timing();  // R9: idle cycles drop valid and hold result
        logic [31:0] held;
        run_case(32'h4020_0000, 2'd0, 32'h4040_0000, "R9");
        held = out_result;
        in_operand = 32'h3FC0_0000;
        @(negedge clk);
        check("R9", {31'd0, out_valid}, 32'd0);
        check("R9", out_result, held);
        rst_n = 1'b0;
        @(negedge clk);
        check("R10", {31'd0, out_valid}, 32'd0);
        check("R10", out_result, 32'd0);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (2) @(negedge clk);
        test_reset();
        rst_n = 1'b1;
        test_zeros();
        test_halves();
        test_ties();
        test_near_integers();
        test_specials();
        test_denormals();
        test_timing();
        repeat (2) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule